// File: doc/BRIEF.md
# LCD Controller Register and Interrupt Block

This block is the software-visible control plane of a raster LCD controller. It sits on a simple 32-bit bus that is addressed by word, with one access per cycle. It holds four panel timing words, an upper and a lower frame base address, a control word, an interrupt mask and a raw interrupt status. From these registers it drives the controller enable, the pixel-depth code, the active width and the active height as plain outputs, along with a level interrupt. A frame tick from the display timing logic posts two frame-event status bits while the controller is on.

The bus window is 4 KB, which is 1024 words. The palette words in the middle of the window are forwarded, unchanged, to a separate palette store. Eight read-only identification bytes sit at the top of the window. The parameter `VARIANT` selects the register map:
- 0 is the base map.
- 1 swaps the word offsets of the mask and control registers.
- 2 swaps those offsets as well and also reports the extended identification bytes.

Reads return data one cycle after the request. The bus has no stall, so back-pressure never arises.

Top module: `lcdc_regs`

## Requirements
- R1: After reset every register and status bit is zero. As a result `disp_en` and `irq` are low, `act_width` is 16 and `act_height` is 1.
- R2: `disp_en` is high only when bit 0 (enable) and bit 11 (power) of the control word are both set.
- R3: `pix_depth` equals control bits [3:1]. Codes 0 to 5 select 1, 2, 4, 8, 16 and 32 bits per pixel, code 6 selects 16-bit 5:6:5 and code 7 selects 12-bit.
- R4: `act_width` = ((timing0 & 0xFC) + 4) * 4. `act_height` = (timing1 & 0x3FF) + 1.
- R5: Word offsets 0 to 3 (timing) and 4 and 5 (upper and lower base) are read/write. Offsets 11 and 12 read back the upper and lower base, and writes to them, or to 8 and 9, are ignored. A read at word address A in cycle N returns `bus_rdata` with `bus_rvalid` high in cycle N+1. `bus_rd` and `bus_wr` are never high together.
- R6: With `VARIANT`=0, word offset 6 is the mask and offset 7 is the control word. With any other value the two offsets are swapped, for reads and for writes.
- R7: Word offsets 0x3F8 to 0x3FF return one identification byte each, in bits [7:0]. For `VARIANT` 0 and 1 the bytes are 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1. For `VARIANT` 2 they are 0x11, 0x11, 0x24, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R8: A cycle with `frame_tick` high while `disp_en` is high sets status bit 2 (next base) and status bit 3 (vertical compare) in the next cycle. While `disp_en` is low the tick leaves the status unchanged.
- R9: A write to word offset 10 clears every status bit that is 1 in `bus_wdata[4:0]`. A frame tick in the same cycle wins over the clear.
- R10: Word offset 8 reads the raw status, and word offset 9 reads the status ANDed with the mask. The mask holds bits [4:0] only. `irq` is high exactly when (status AND mask) is nonzero.
- R11: Word offsets 0x80 to 0xFF are palette words. An access there drives `pal_rd` or `pal_wr` in the same cycle, with `pal_idx` = offset - 0x80 and `pal_wdata` = `bus_wdata`. A read returns the `pal_rdata` value seen in the access cycle.
- R12: Reads of any other word offset return 0, and writes to them change nothing. For each such access `bus_err` pulses high in the following cycle. Offset 10 is not counted as unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_rd | input | 1 | Read request this cycle |
| bus_wr | input | 1 | Write request this cycle |
| bus_waddr | input | 10 | Word address within the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| bus_err | output | 1 | Pulse for an access to an unmapped offset |
| frame_tick | input | 1 | One-cycle frame event from the timing logic |
| pal_rd | output | 1 | Palette read strobe |
| pal_wr | output | 1 | Palette write strobe |
| pal_idx | output | 7 | Palette word index |
| pal_wdata | output | 32 | Palette write data |
| pal_rdata | input | 32 | Palette read data, combinational from `pal_idx` |
| disp_en | output | 1 | Controller enabled (enable and power both set) |
| pix_depth | output | 3 | Pixel depth code |
| act_width | output | 11 | Active width in pixels |
| act_height | output | 11 | Active height in lines |
| irq | output | 1 | Level interrupt |

## Verification
The assertions take two things about the inputs for granted:
- A read and a write never share a cycle.
- All inputs are low while reset is held.

Under those conditions, one cycle after a request the status and `bus_rvalid` must reflect exactly that request. The stimulus issues one access per task call, with idle cycles in between, and holds every input at zero throughout reset. It pulses `frame_tick` both alone and in the same cycle as a clear, so the tick-wins ordering is exercised without ever breaking the read/write exclusion.

// File: rtl/lcdc_regs_pkg.sv
package lcdc_regs_pkg;

  // Register selected by the decoded word address.
  typedef enum logic [3:0] {
    RG_NONE, RG_TIM, RG_UPB, RG_LPB, RG_MASK, RG_CTRL, RG_RIS,
    RG_MIS, RG_ICR, RG_UPCUR, RG_LPCUR, RG_PAL, RG_ID
  } reg_sel_e;

  localparam int ST_W     = 5;   // status and mask width
  localparam int NB_BIT   = 2;   // next-base status bit
  localparam int VC_BIT   = 3;   // vertical-compare status bit
  localparam int EN_BIT   = 0;
  localparam int PWR_BIT  = 11;
  localparam int DEPTH_LO = 1;
  localparam int DEPTH_W  = 3;
  localparam int DIM_W    = 11;  // width and height in pixels/lines

  // Identification byte idx; ext picks the extended set.
  function automatic logic [7:0] id_lookup(input logic ext, input logic [2:0] idx);
    case (idx)
      3'd0:    id_lookup = ext ? 8'h11 : 8'h10;
      3'd1:    id_lookup = 8'h11;
      3'd2:    id_lookup = ext ? 8'h24 : 8'h04;
      3'd3:    id_lookup = 8'h00;
      3'd4:    id_lookup = 8'h0D;
      3'd5:    id_lookup = 8'hF0;
      3'd6:    id_lookup = 8'h05;
      default: id_lookup = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/lcdc_regs_dec.sv
module lcdc_regs_dec
  import lcdc_regs_pkg::*;
#(
  parameter int VARIANT = 0,
  parameter int WORD_AW = 10,
  parameter int PAL_AW  = 7
) (
  input  logic [WORD_AW-1:0] waddr,
  output reg_sel_e           sel,
  output logic [1:0]         tim_idx
);
  localparam int ID_WORDS = 8;
  localparam logic [WORD_AW-1:0] ID_BASE = WORD_AW'((1 << WORD_AW) - ID_WORDS);
  localparam logic [WORD_AW-PAL_AW-1:0] PAL_TAG = 1;

  reg_sel_e slot6, slot7;

  // The variant picks which of the two slots is the mask.
  generate
    if (VARIANT == 0) begin : g_base_map
      assign slot6 = RG_MASK;
      assign slot7 = RG_CTRL;
    end else begin : g_swap_map
      assign slot6 = RG_CTRL;
      assign slot7 = RG_MASK;
    end
  endgenerate

  assign tim_idx = waddr[1:0];

  always_comb begin
    sel = RG_NONE;
    if (waddr >= ID_BASE) begin
      sel = RG_ID;
    end else if (waddr[WORD_AW-1:PAL_AW] == PAL_TAG) begin
      sel = RG_PAL;
    end else begin
      case (waddr)
        WORD_AW'(0), WORD_AW'(1), WORD_AW'(2), WORD_AW'(3): sel = RG_TIM;
        WORD_AW'(4):  sel = RG_UPB;
        WORD_AW'(5):  sel = RG_LPB;
        WORD_AW'(6):  sel = slot6;
        WORD_AW'(7):  sel = slot7;
        WORD_AW'(8):  sel = RG_RIS;
        WORD_AW'(9):  sel = RG_MIS;
        WORD_AW'(10): sel = RG_ICR;
        WORD_AW'(11): sel = RG_UPCUR;
        WORD_AW'(12): sel = RG_LPCUR;
        default:      sel = RG_NONE;
      endcase
    end
  end
endmodule

// File: rtl/lcdc_regs_id.sv
module lcdc_regs_id
  import lcdc_regs_pkg::*;
#(
  parameter int VARIANT = 0
) (
  input  logic [2:0] idx,
  output logic [7:0] id_byte
);
  generate
    if (VARIANT == 2) begin : g_ext_id
      assign id_byte = id_lookup(1'b1, idx);
    end else begin : g_base_id
      assign id_byte = id_lookup(1'b0, idx);
    end
  endgenerate
endmodule

// File: rtl/lcdc_regs_irq.sv
module lcdc_regs_irq
  import lcdc_regs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_set,
  input  logic            clr_we,
  input  logic [ST_W-1:0] clr_bits,
  input  logic            mask_we,
  input  logic [ST_W-1:0] mask_din,
  output logic [ST_W-1:0] status,
  output logic [ST_W-1:0] mask,
  output logic            irq
);
  localparam logic [ST_W-1:0] FRAME_SET =
    (ST_W'(1) << NB_BIT) | (ST_W'(1) << VC_BIT);

  logic [ST_W-1:0] clr_vec, set_vec;

  assign clr_vec = clr_we ? clr_bits : '0;
  assign set_vec = tick_set ? FRAME_SET : '0;

  // The set is applied after the clear, so a tick wins over a clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= '0;
    end else begin
      status <= (status & ~clr_vec) | set_vec;
      if (mask_we) mask <= mask_din;
    end
  end

  assign irq = |(status & mask);
endmodule

// File: rtl/lcdc_regs.sv
module lcdc_regs
  import lcdc_regs_pkg::*;
#(
  parameter int VARIANT = 0,
  parameter int WORD_AW = 10,
  parameter int DW      = 32,
  parameter int PAL_AW  = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [WORD_AW-1:0] bus_waddr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic               bus_rvalid,
  output logic               bus_err,
  input  logic               frame_tick,
  output logic               pal_rd,
  output logic               pal_wr,
  output logic [PAL_AW-1:0]  pal_idx,
  output logic [DW-1:0]      pal_wdata,
  input  logic [DW-1:0]      pal_rdata,
  output logic               disp_en,
  output logic [DEPTH_W-1:0] pix_depth,
  output logic [DIM_W-1:0]   act_width,
  output logic [DIM_W-1:0]   act_height,
  output logic               irq
);
  localparam int N_TIM = 4;
  localparam int HGT_FIELD = 10;
  localparam int WID_SUM_W = DIM_W - 4;

  reg_sel_e                sel;
  logic [1:0]              tim_idx;
  logic [N_TIM-1:0][DW-1:0] tim_q;
  logic [DW-1:0]           upb_q, lpb_q, ctrl_q;
  logic [ST_W-1:0]         st_q, mask_q;
  logic [7:0]              id_b;
  logic [DW-1:0]           rd_mux;
  logic [WID_SUM_W-1:0]    wid_sum;

  lcdc_regs_dec #(.VARIANT(VARIANT), .WORD_AW(WORD_AW), .PAL_AW(PAL_AW)) u_dec (
    .waddr   (bus_waddr),
    .sel     (sel),
    .tim_idx (tim_idx)
  );

  lcdc_regs_id #(.VARIANT(VARIANT)) u_id (
    .idx     (bus_waddr[2:0]),
    .id_byte (id_b)
  );

  lcdc_regs_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_set (frame_tick & disp_en),
    .clr_we   (bus_wr && sel == RG_ICR),
    .clr_bits (bus_wdata[ST_W-1:0]),
    .mask_we  (bus_wr && sel == RG_MASK),
    .mask_din (bus_wdata[ST_W-1:0]),
    .status   (st_q),
    .mask     (mask_q),
    .irq      (irq)
  );

  // Writable registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tim_q  <= '0;
      upb_q  <= '0;
      lpb_q  <= '0;
      ctrl_q <= '0;
    end else if (bus_wr) begin
      for (int i = 0; i < N_TIM; i++) begin
        if (sel == RG_TIM && tim_idx == 2'(i)) tim_q[i] <= bus_wdata;
      end
      if (sel == RG_UPB)  upb_q  <= bus_wdata;
      if (sel == RG_LPB)  lpb_q  <= bus_wdata;
      if (sel == RG_CTRL) ctrl_q <= bus_wdata;
    end
  end

  // Read data select
  always_comb begin
    case (sel)
      RG_TIM:            rd_mux = tim_q[tim_idx];
      RG_UPB, RG_UPCUR:  rd_mux = upb_q;
      RG_LPB, RG_LPCUR:  rd_mux = lpb_q;
      RG_MASK:           rd_mux = DW'(mask_q);
      RG_CTRL:           rd_mux = ctrl_q;
      RG_RIS:            rd_mux = DW'(st_q);
      RG_MIS:            rd_mux = DW'(st_q & mask_q);
      RG_PAL:            rd_mux = pal_rdata;
      RG_ID:             rd_mux = DW'(id_b);
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      bus_err    <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      bus_rdata  <= bus_rd ? rd_mux : '0;
      bus_err    <= (bus_rd | bus_wr) && sel == RG_NONE;
    end
  end

  // Palette pass-through
  assign pal_rd    = bus_rd && sel == RG_PAL;
  assign pal_wr    = bus_wr && sel == RG_PAL;
  assign pal_idx   = bus_waddr[PAL_AW-1:0];
  assign pal_wdata = bus_wdata;

  // Derived display settings
  assign disp_en    = ctrl_q[EN_BIT] & ctrl_q[PWR_BIT];
  assign pix_depth  = ctrl_q[DEPTH_LO +: DEPTH_W];
  assign wid_sum    = WID_SUM_W'(tim_q[0][7:2]) + WID_SUM_W'(1);
  assign act_width  = {wid_sum, 4'b0000};
  assign act_height = DIM_W'(tim_q[1][HGT_FIELD-1:0]) + DIM_W'(1);
endmodule

// File: rtl/lcdc_regs_chk.sv
module lcdc_regs_chk
  import lcdc_regs_pkg::*;
#(
  parameter int WORD_AW = 10,
  parameter int DW      = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_rd,
  input logic               bus_wr,
  input logic [WORD_AW-1:0] bus_waddr,
  input logic [DW-1:0]      bus_wdata,
  input logic               frame_tick,
  input logic               disp_en,
  input logic [ST_W-1:0]    status,
  input logic               irq,
  input logic               bus_rvalid
);
  // R5
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  // R5
  rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  // R5
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);

  // R8
  tick_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && disp_en) |=> (status[VC_BIT] && status[NB_BIT]));

  // R8
  tick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_en && !bus_wr) |=> $stable(status));

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_waddr == WORD_AW'(10) && !frame_tick)
      |=> ((status & $past(bus_wdata[ST_W-1:0])) == '0));

  // R10
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(bus_wr));
endmodule

bind lcdc_regs lcdc_regs_chk #(.WORD_AW(WORD_AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .bus_waddr  (bus_waddr),
  .bus_wdata  (bus_wdata),
  .frame_tick (frame_tick),
  .disp_en    (disp_en),
  .status     (st_q),
  .irq        (irq),
  .bus_rvalid (bus_rvalid)
);

// File: tb/lcdc_regs_tb.sv
module lcdc_regs_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_rd = 1'b0, bus_wr = 1'b0, frame_tick = 1'b0;
  logic [9:0]  bus_waddr = '0;
  logic [31:0] bus_wdata = '0;

  // Outputs: index 0 = VARIANT 0, index 1 = VARIANT 2
  logic [31:0] rdata [2];
  logic        rvalid [2], err [2], prd [2], pwr [2], en [2], irq [2];
  logic [6:0]  pidx [2];
  logic [31:0] pwd [2];
  logic [2:0]  depth [2];
  logic [10:0] wid [2], hgt [2];

  logic [31:0] pal_mem [128];
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  lcdc_regs #(.VARIANT(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_rdata(rdata[0]),
    .bus_rvalid(rvalid[0]), .bus_err(err[0]), .frame_tick(frame_tick),
    .pal_rd(prd[0]), .pal_wr(pwr[0]), .pal_idx(pidx[0]), .pal_wdata(pwd[0]),
    .pal_rdata(pal_mem[pidx[0]]), .disp_en(en[0]), .pix_depth(depth[0]),
    .act_width(wid[0]), .act_height(hgt[0]), .irq(irq[0]));

  lcdc_regs #(.VARIANT(2)) u_dut_x (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_rdata(rdata[1]),
    .bus_rvalid(rvalid[1]), .bus_err(err[1]), .frame_tick(frame_tick),
    .pal_rd(prd[1]), .pal_wr(pwr[1]), .pal_idx(pidx[1]), .pal_wdata(pwd[1]),
    .pal_rdata(pal_mem[pidx[1]]), .disp_en(en[1]), .pix_depth(depth[1]),
    .act_width(wid[1]), .act_height(hgt[1]), .irq(irq[1]));

  // Palette store shared by both instances, written by the first one
  initial for (int i = 0; i < 128; i++) pal_mem[i] = '0;
  always @(posedge clk) if (pwr[0]) pal_mem[pidx[0]] <= pwd[0];

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_tim [4];
  logic [31:0] m_upb, m_lpb;
  logic [31:0] m_pal [128];
  logic [31:0] m_ctrl [2];
  logic [4:0]  m_mask [2], m_st [2];
  logic [31:0] m_rdata [2];
  string       m_tag [2];
  logic        m_rvalid, m_err;

  function automatic logic [7:0] ref_id(int v, int i);
    logic [7:0] b [8];
    b = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    if (v == 1 && i == 0) return 8'h11;
    if (v == 1 && i == 2) return 8'h24;
    return b[i];
  endfunction

  function automatic bit is_mapped(int a);
    return (a <= 12) || (a >= 'h80 && a <= 'hFF) || (a >= 'h3F8);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_tim[i] = '0;
      m_upb = '0; m_lpb = '0; m_rvalid = 0; m_err = 0;
      for (int i = 0; i < 128; i++) m_pal[i] = '0;
      for (int v = 0; v < 2; v++) begin
        m_ctrl[v] = '0; m_mask[v] = '0; m_st[v] = '0; m_rdata[v] = '0; m_tag[v] = "R1";
      end
    end else begin
      int a;
      a = int'(bus_waddr);
      for (int v = 0; v < 2; v++) begin
        int ctrl_off, mask_off;
        bit on;
        logic [4:0] clr, setb;
        ctrl_off = (v == 0) ? 7 : 6;
        mask_off = (v == 0) ? 6 : 7;
        on = m_ctrl[v][0] && m_ctrl[v][11];
        if (bus_rd) begin
          m_rdata[v] = 32'h0; m_tag[v] = "R12";
          if (a >= 'h3F8) begin m_rdata[v] = {24'h0, ref_id(v, a - 'h3F8)}; m_tag[v] = "R7"; end
          else if (a >= 'h80 && a <= 'hFF) begin m_rdata[v] = m_pal[a - 'h80]; m_tag[v] = "R11"; end
          else if (a <= 3) begin m_rdata[v] = m_tim[a]; m_tag[v] = "R5"; end
          else if (a == 4 || a == 11) begin m_rdata[v] = m_upb; m_tag[v] = "R5"; end
          else if (a == 5 || a == 12) begin m_rdata[v] = m_lpb; m_tag[v] = "R5"; end
          else if (a == ctrl_off) begin m_rdata[v] = m_ctrl[v]; m_tag[v] = "R6"; end
          else if (a == mask_off) begin m_rdata[v] = {27'h0, m_mask[v]}; m_tag[v] = "R6"; end
          else if (a == 8) begin m_rdata[v] = {27'h0, m_st[v]}; m_tag[v] = "R10"; end
          else if (a == 9) begin m_rdata[v] = {27'h0, m_st[v] & m_mask[v]}; m_tag[v] = "R10"; end
        end
        clr  = (bus_wr && a == 10) ? bus_wdata[4:0] : 5'h0;
        setb = (frame_tick && on) ? 5'b01100 : 5'h0;
        m_st[v] = (m_st[v] & ~clr) | setb;
        if (bus_wr && a == ctrl_off) m_ctrl[v] = bus_wdata;
        if (bus_wr && a == mask_off) m_mask[v] = bus_wdata[4:0];
      end
      if (bus_wr && a <= 3) m_tim[a] = bus_wdata;
      if (bus_wr && a == 4) m_upb = bus_wdata;
      if (bus_wr && a == 5) m_lpb = bus_wdata;
      if (bus_wr && a >= 'h80 && a <= 'hFF) m_pal[a - 'h80] = bus_wdata;
      m_rvalid = bus_rd;
      m_err = (bus_rd || bus_wr) && !is_mapped(a);
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare both instances with the model on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      for (int v = 0; v < 2; v++) begin
        chk("R2 disp_en", 32'(en[v]), 32'(m_ctrl[v][0] & m_ctrl[v][11]));
        chk("R3 pix_depth", 32'(depth[v]), 32'(m_ctrl[v][3:1]));
        chk("R4 act_width", 32'(wid[v]), ((m_tim[0] & 32'hFC) + 32'd4) * 32'd4);
        chk("R4 act_height", 32'(hgt[v]), (m_tim[1] & 32'h3FF) + 32'd1);
        chk("R10 irq", 32'(irq[v]), 32'(|(m_st[v] & m_mask[v])));
        chk("R5 rvalid", 32'(rvalid[v]), 32'(m_rvalid));
        chk("R12 bus_err", 32'(err[v]), 32'(m_err));
        if (m_rvalid) chk({m_tag[v], " rdata"}, rdata[v], m_rdata[v]);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); #1;
    bus_wr = 1; bus_waddr = 10'(a); bus_wdata = d;
    @(negedge clk); #1;
    bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rd2(int a, logic [31:0] e0, logic [31:0] e1, string tag);
    @(negedge clk); #1;
    bus_rd = 1; bus_waddr = 10'(a);
    @(negedge clk);
    chk(tag, rdata[0], e0);
    chk(tag, rdata[1], e1);
    #1 bus_rd = 0;
  endtask

  task automatic tick(bit with_clear, logic [31:0] clr);
    @(negedge clk); #1;
    frame_tick = 1;
    if (with_clear) begin bus_wr = 1; bus_waddr = 10'd10; bus_wdata = clr; end
    @(negedge clk); #1;
    frame_tick = 0; bus_wr = 0; bus_wdata = '0;
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 disp_en", 32'(en[0]), 0);
    chk("R1 irq", 32'(irq[0]), 0);
    chk("R1 width", 32'(wid[0]), 16);
    chk("R1 height", 32'(hgt[1]), 1);
    rd2(8, 0, 0, "R1 status");
    rd2(7, 0, 0, "R1 ctrl");

    // R4 dimension decode
    wr(0, 32'h0000_00FC);
    @(negedge clk); chk("R4 width max", 32'(wid[0]), 1024);
    wr(0, 32'h1234_5678);
    @(negedge clk); chk("R4 width packed", 32'(wid[1]), 496);
    wr(1, 32'hABCD_E3FF);
    @(negedge clk); chk("R4 height max", 32'(hgt[0]), 1024);
    wr(1, 32'h0000_0005);
    @(negedge clk); chk("R4 height", 32'(hgt[0]), 6);

    // R5 plain registers and mirrors
    wr(2, 32'hCAFE_0002); wr(3, 32'hCAFE_0003);
    wr(4, 32'h8000_1000); wr(5, 32'h8000_2000);
    rd2(0, 32'h1234_5678, 32'h1234_5678, "R5 timing0");
    rd2(3, 32'hCAFE_0003, 32'hCAFE_0003, "R5 timing3");
    rd2(11, 32'h8000_1000, 32'h8000_1000, "R5 upper mirror");
    rd2(12, 32'h8000_2000, 32'h8000_2000, "R5 lower mirror");
    wr(11, 32'hFFFF_FFFF); wr(8, 32'hFFFF_FFFF);
    rd2(4, 32'h8000_1000, 32'h8000_1000, "R5 ignored write");

    // R6 slot swap
    wr(7, 32'h0000_0801);
    rd2(7, 32'h0000_0801, 32'h0000_0001, "R6 offset7");
    rd2(6, 0, 0, "R6 offset6");
    wr(6, 32'h0000_0809);
    rd2(6, 32'h0000_0009, 32'h0000_0809, "R6 offset6 written");
    @(negedge clk);
    chk("R2 enabled", 32'(en[0]), 1);
    chk("R3 depth16", 32'(depth[1]), 4);

    // R8 / R10 frame tick and interrupt
    tick(0, 0);
    @(negedge clk);
    chk("R10 irq base", 32'(irq[0]), 1);
    chk("R10 irq swap", 32'(irq[1]), 0);
    rd2(8, 32'h0C, 32'h0C, "R8 raw status");
    rd2(9, 32'h08, 32'h00, "R10 masked status");

    // R9 clear and tick-wins ordering
    wr(10, 32'h8);
    rd2(8, 32'h04, 32'h04, "R9 clear");
    chk("R9 irq low", 32'(irq[0]), 0);
    tick(1, 32'h0C);
    rd2(8, 32'h0C, 32'h0C, "R9 tick wins");

    // R10 mask width
    wr(6, 32'hFFFF_FFFF);
    rd2(6, 32'h1F, 32'hFFFF_FFFF, "R10 mask bits");

    // R8 tick ignored while disabled
    wr(7, 32'h0000_0001);
    wr(6, 32'h0000_0800);
    wr(10, 32'h1F);
    tick(0, 0);
    rd2(8, 0, 0, "R8 disabled tick");

    // R2 / R3 enable combinations and every depth code
    wr(7, 32'h0000_0800);
    @(negedge clk); chk("R2 power only", 32'(en[0]), 0);
    for (int d = 0; d < 8; d++) begin
      wr(7, 32'h0000_0801 | (32'(d) << 1));
      @(negedge clk);
      chk("R3 depth code", 32'(depth[0]), 32'(d));
      chk("R2 enable+power", 32'(en[0]), 1);
    end

    // R11 palette forwarding
    wr('h80, 32'hDEAD_BEEF);
    wr('hFF, 32'h1234_5678);
    chk("R11 palette store", pal_mem[0], 32'hDEAD_BEEF);
    chk("R11 palette index", pal_mem[127], 32'h1234_5678);
    rd2('h80, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R11 palette read");
    rd2('hFF, 32'h1234_5678, 32'h1234_5678, "R11 palette read top");

    // R7 identification bytes
    for (int i = 0; i < 8; i++)
      rd2('h3F8 + i, 32'(ref_id(0, i)), 32'(ref_id(1, i)), "R7 id byte");

    // R12 unmapped offsets
    rd2(13, 0, 0, "R12 read zero");
    chk("R12 err pulse", 32'(err[0]), 1);
    wr('h40, 32'hFFFF_FFFF);
    chk("R12 err on write", 32'(err[1]), 1);
    rd2('h40, 0, 0, "R12 write ignored");
    rd2(0, 32'h1234_5678, 32'h1234_5678, "R12 no side effect");

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule